// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a single-beat synchronous request port and an external asynchronous static RAM that is 16 bits wide and has two byte lanes. A client offers an access when `req_ready` is high. The access carries a direction flag, an address, write data and a two-bit lane mask. At acceptance the block captures all request fields. It then plays out the pin sequence for that access on the memory strobes and the split data bus. For a read, it returns the sampled word with a one-cycle `rsp_valid` pulse.

Each phase length is a clock count. The count is derived from nanosecond parameters: it is the timing value divided by `CLK_NS`, rounded up, and never less than one clock. A write keeps the write strobe low for the longer of the pulse-width time and the data-setup time. After that it holds one extra clock with the strobe high while chip select, lanes, address and data stay unchanged. A read keeps output enable low for the access time and samples the bus at the end. When a write's previous access was a read, the block inserts a bus turnaround gap sized from the output-release time. When no access is in flight, chip select stays high so the memory can power down.

Top module: `sram_bridge`

## Requirements
- R1: While `rst_n` is low, all five memory strobes are high, `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: In any cycle with no access in progress, `mem_ce_n` is high and `req_ready` is high.
- R3: Phase lengths in clocks are ceil(ns / `CLK_NS`) with a floor of 1. The write-strobe length is the larger of the pulse-width count and the data-setup count.
- R4: A write drives `mem_ce_n` and `mem_we_n` low with `mem_dq_oe` high for the write-strobe length. Next comes exactly one clock with `mem_we_n` high, `mem_ce_n` low and `mem_dq_oe` still high. The block then returns to idle.
- R5: Lane mask bit 0 selects data bits 7..0 through `mem_lb_n`, and bit 1 selects bits 15..8 through `mem_ub_n`. A lane enable is low only when its mask bit is 1 and `mem_ce_n` is low.
- R6: A read holds `mem_ce_n` and `mem_oe_n` low, with `mem_we_n` high, for the access count. It samples `mem_dq_in` at the end of the last access clock. `rsp_valid` is then high for exactly one clock with the data.
- R7: In read data, every bit of a lane whose mask bit is 0 is returned as 0.
- R8: A write whose previous access was a read first spends the turnaround count of clocks with all strobes high and `mem_dq_oe` 0. Other orderings start with no gap.
- R9: `req_ready` is low from the clock after acceptance until the access ends. Requests presented while it is low are ignored.
- R10: During an access, `mem_addr`, the lane enables and `mem_dq_out` keep the values captured at acceptance, whatever the request inputs do.
- R11: `mem_dq_oe` is never high while `mem_oe_n` is low, nor in the clock that follows one with `mem_oe_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Access offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 16 | Write data |
| req_lanes | input | 2 | Lane mask, bit 1 = upper byte, bit 0 = lower byte |
| req_ready | output | 1 | Block can accept an access this cycle |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, disabled lanes zeroed |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_ub_n | output | 1 | Upper byte lane enable, active low |
| mem_lb_n | output | 1 | Lower byte lane enable, active low |
| mem_addr | output | AW | Memory address |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 16 | Data sampled from the memory bus |

## Verification
The hardest situation to reach is a write accepted in the very clock that carries a read response. That is the only path into the turnaround gap with no idle clock in between, and it must also stay clean while the request inputs keep toggling. The bench reaches it by queuing accesses back to back. After each acceptance it leaves `req_valid` high with random fields, so that ignored requests overlap every phase. A long random mix of reads and writes over a few repeated addresses then merges partial-lane writes. Reads with mixed masks check those merges against a byte-accurate reference memory.

// File: rtl/sram_bridge.sv
module sram_bridge #(
  parameter int CLK_NS   = 20,
  parameter int T_ACC_NS = 10,
  parameter int T_WP_NS  = 7,
  parameter int T_SD_NS  = 5,
  parameter int T_OHZ_NS = 5,
  parameter int AW       = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [15:0]   req_wdata,
  input  logic [1:0]    req_lanes,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [15:0]   rsp_rdata,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [15:0]   mem_dq_in
);

  function automatic int ns2cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int ACC_C = ns2cyc(T_ACC_NS);
  localparam int WP_C  = (ns2cyc(T_WP_NS) > ns2cyc(T_SD_NS)) ? ns2cyc(T_WP_NS) : ns2cyc(T_SD_NS);
  localparam int TA_C  = ns2cyc(T_OHZ_NS);
  localparam int CMAX  = (ACC_C > WP_C) ? ((ACC_C > TA_C) ? ACC_C : TA_C)
                                        : ((WP_C > TA_C) ? WP_C : TA_C);
  localparam int CW    = (CMAX > 1) ? $clog2(CMAX) : 1;

  typedef enum logic [2:0] {S_IDLE, S_TURN, S_WR, S_WEND, S_RD} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] addr_q;
  logic [15:0]   wd_q;
  logic [1:0]    lanes_q;
  logic          rd_last;

  wire sel = (st == S_WR) || (st == S_WEND) || (st == S_RD);

  assign req_ready  = (st == S_IDLE);
  assign mem_ce_n   = !sel;
  assign mem_we_n   = (st != S_WR);
  assign mem_oe_n   = (st != S_RD);
  assign mem_lb_n   = !(sel && lanes_q[0]);
  assign mem_ub_n   = !(sel && lanes_q[1]);
  assign mem_addr   = addr_q;
  assign mem_dq_out = wd_q;
  assign mem_dq_oe  = (st == S_WR) || (st == S_WEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      cnt       <= '0;
      addr_q    <= '0;
      wd_q      <= '0;
      lanes_q   <= '0;
      rd_last   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wd_q    <= req_wdata;
          lanes_q <= req_lanes;
          cnt     <= '0;
          st      <= !req_write ? S_RD : (rd_last ? S_TURN : S_WR);
        end
        S_TURN: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(TA_C - 1)) begin
            cnt <= '0;
            st  <= S_WR;
          end
        end
        S_WR: begin
          rd_last <= 1'b0;
          cnt     <= cnt + 1'b1;
          if (cnt == CW'(WP_C - 1)) begin
            cnt <= '0;
            st  <= S_WEND;
          end
        end
        S_WEND: st <= S_IDLE;
        S_RD: begin
          cnt <= cnt + 1'b1;
          if (cnt == CW'(ACC_C - 1)) begin
            cnt       <= '0;
            rsp_rdata <= mem_dq_in & {{8{lanes_q[1]}}, {8{lanes_q[0]}}};
            rsp_valid <= 1'b1;
            rd_last   <= 1'b1;
            st        <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_bridge_chk.sv
module sram_bridge_chk #(
  parameter int AW      = 16,
  parameter int CLK_NS  = 20,
  parameter int T_WP_NS = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          mem_ce_n,
  input logic          mem_we_n,
  input logic          mem_oe_n,
  input logic          mem_ub_n,
  input logic          mem_lb_n,
  input logic [AW-1:0] mem_addr,
  input logic [15:0]   mem_dq_out,
  input logic          mem_dq_oe
);

  localparam int WP_MIN = ((T_WP_NS + CLK_NS - 1) / CLK_NS < 1) ? 1 : (T_WP_NS + CLK_NS - 1) / CLK_NS;

  logic [15:0] wlow;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wlow <= '0;
    else if (!mem_we_n) wlow <= (wlow == 16'hFFFF) ? wlow : wlow + 16'd1;
    else                wlow <= '0;
  end

  p_idle_powerdown_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> mem_ce_n);

  p_strobe_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wlow >= 16'(WP_MIN)));

  p_we_ends_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (!mem_ce_n && mem_dq_oe && $stable({mem_ub_n, mem_lb_n})
                         && $stable(mem_addr) && $stable(mem_dq_out)));

  p_we_needs_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  p_lane_needs_ce_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ub_n || !mem_lb_n) |-> !mem_ce_n);

  p_read_strobes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n));

  p_rsp_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_rsp_then_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready);

  p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  p_no_fight_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dq_oe);

  p_turnaround_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |=> !mem_dq_oe);

endmodule

bind sram_bridge sram_bridge_chk #(.AW(AW), .CLK_NS(CLK_NS), .T_WP_NS(T_WP_NS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
  .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_addr(mem_addr),
  .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_bridge.sv
module test_sram_bridge;
  localparam int CLK_NS = 20, T_ACC = 50, T_WP = 45, T_SD = 30, T_OHZ = 25, AW = 16;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  // R3: expected phase lengths, from the requirement
  localparam int ACC_N = cyc(T_ACC);
  localparam int WP_N  = (cyc(T_WP) > cyc(T_SD)) ? cyc(T_WP) : cyc(T_SD);
  localparam int TA_N  = cyc(T_OHZ);

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_lanes = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0] rsp_rdata, mem_dq_out, mem_dq_in = 16'h5AC3;
  logic [AW-1:0] mem_addr;

  always #10 clk = ~clk;

  sram_bridge #(.CLK_NS(CLK_NS), .T_ACC_NS(T_ACC), .T_WP_NS(T_WP), .T_SD_NS(T_SD),
                .T_OHZ_NS(T_OHZ), .AW(AW)) i_sram_bridge (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_lanes(req_lanes),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

  typedef struct {
    bit ce, we, oe, ub, lb, dqoe, rdy, rsp;
    bit [15:0] addr, wd, rd;
    int tag, rtag;
  } vec_t;

  vec_t q[$];
  bit cur_ready = 1, last_rd = 0;
  logic [15:0] ref_mem[int];
  logic [15:0] sram[int];
  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input int tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic vec_t idle_v();
    vec_t v;
    v.ce = 1; v.we = 1; v.oe = 1; v.ub = 1; v.lb = 1; v.dqoe = 0; v.rdy = 1; v.rsp = 0;
    v.addr = '0; v.wd = '0; v.rd = '0; v.tag = 2; v.rtag = 6; // R2 idle
    return v;
  endfunction

  function automatic logic [15:0] rd_word(input logic [15:0] m[int], input int a);
    return m.exists(a) ? m[a] : 16'h0000;
  endfunction

  // behavioural memory on the pins
  always @(posedge clk) begin
    if (rst_n && !mem_ce_n && !mem_we_n && mem_dq_oe) begin
      logic [15:0] w;
      w = rd_word(sram, int'(mem_addr));
      if (!mem_lb_n) w[7:0]  = mem_dq_out[7:0];
      if (!mem_ub_n) w[15:8] = mem_dq_out[15:8];
      sram[int'(mem_addr)] = w;
    end
  end
  always @(negedge clk) begin
    logic [15:0] r;
    r = rd_word(sram, int'(mem_addr));
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      mem_dq_in <= {mem_ub_n ? 8'hC3 : r[15:8], mem_lb_n ? 8'h3C : r[7:0]};
    else
      mem_dq_in <= 16'h5AC3;
  end

  // reference model: expected pin vectors queued at acceptance
  always @(posedge clk) begin
    if (rst_n && req_valid && cur_ready) begin
      vec_t v;
      v = idle_v();
      v.rdy = 0; v.addr = req_addr; v.wd = req_wdata;
      if (req_write) begin
        logic [15:0] w;
        if (last_rd) for (int i = 0; i < TA_N; i++) begin
          v.tag = 8; q.push_back(v); // R8 turnaround gap
        end
        v.ce = 0; v.we = 0; v.dqoe = 1; v.ub = !req_lanes[1]; v.lb = !req_lanes[0];
        v.tag = 3; // R3 strobe length
        for (int i = 0; i < WP_N; i++) q.push_back(v);
        v.we = 1; v.tag = 4; // R4 strobe raised first
        q.push_back(v);
        w = rd_word(ref_mem, int'(req_addr));
        if (req_lanes[0]) w[7:0]  = req_wdata[7:0];
        if (req_lanes[1]) w[15:8] = req_wdata[15:8];
        ref_mem[int'(req_addr)] = w;
        last_rd = 0;
      end else begin
        v.ce = 0; v.oe = 0; v.ub = !req_lanes[1]; v.lb = !req_lanes[0]; v.tag = 6; // R6
        for (int i = 0; i < ACC_N; i++) q.push_back(v);
        v = idle_v();
        v.rsp = 1;
        v.rd = rd_word(ref_mem, int'(req_addr)) & {{8{req_lanes[1]}}, {8{req_lanes[0]}}};
        v.rtag = (req_lanes == 2'b11) ? 6 : 7; // R7 zeroed lanes
        q.push_back(v);
        last_rd = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      vec_t e;
      e = (q.size() > 0) ? q.pop_front() : idle_v();
      check(mem_ce_n == e.ce, e.tag, "ce_n", 16'(mem_ce_n), 16'(e.ce));
      check(mem_we_n == e.we, e.tag, "we_n", 16'(mem_we_n), 16'(e.we));
      check(mem_oe_n == e.oe, e.tag, "oe_n", 16'(mem_oe_n), 16'(e.oe));
      check(mem_dq_oe == e.dqoe, (e.tag == 8) ? 11 : e.tag, "dq_oe", 16'(mem_dq_oe), 16'(e.dqoe));
      check({mem_ub_n, mem_lb_n} == {e.ub, e.lb}, 5, "lanes", 16'({mem_ub_n, mem_lb_n}), 16'({e.ub, e.lb})); // R5
      check(req_ready == e.rdy, 9, "ready", 16'(req_ready), 16'(e.rdy)); // R9
      check(rsp_valid == e.rsp, 6, "rsp_valid", 16'(rsp_valid), 16'(e.rsp));
      if (e.rsp) check(rsp_rdata == e.rd, e.rtag, "rdata", rsp_rdata, e.rd);
      if (!e.ce) check(mem_addr == e.addr, 10, "addr", mem_addr, e.addr); // R10
      if (e.dqoe) check(mem_dq_out == e.wd, 10, "dq_out", mem_dq_out, e.wd);
      cur_ready = e.rdy;
    end
  end

  task automatic issue(input bit w, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] m, input bit noise);
    do begin @(negedge clk); #1; end while (!cur_ready);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; req_lanes = m;
    @(posedge clk); #1;
    if (noise) begin // R9 / R10: requests while busy must be ignored
      req_valid = 1; req_write = 1'($urandom); req_addr = 16'($urandom);
      req_wdata = 16'($urandom); req_lanes = 2'($urandom);
    end else req_valid = 0;
  endtask

  task automatic gap(input int n);
    @(negedge clk); #1; req_valid = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    // R1 reset state
    check({mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n} == 5'b11111, 1, "strobes in reset",
          16'({mem_ce_n, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n}), 16'h1F);
    check(mem_dq_oe == 0, 1, "dq_oe in reset", 16'(mem_dq_oe), 16'h0);
    check(req_ready == 1, 1, "ready in reset", 16'(req_ready), 16'h1);
    check(rsp_valid == 0, 1, "rsp in reset", 16'(rsp_valid), 16'h0);
    #1 rst_n = 1;
    gap(3);
    issue(1, 16'h0010, 16'h1234, 2'b11, 0);
    issue(1, 16'h0020, 16'hABCD, 2'b01, 1);
    issue(1, 16'h0020, 16'h5566, 2'b10, 1);
    issue(1, 16'h0030, 16'h0F0F, 2'b11, 0);
    issue(1, 16'h0030, 16'hFFFF, 2'b00, 0);
    gap(2);
    issue(0, 16'h0010, 16'h0, 2'b11, 0);
    issue(0, 16'h0020, 16'h0, 2'b11, 1);
    issue(0, 16'h0020, 16'h0, 2'b01, 1);
    issue(0, 16'h0020, 16'h0, 2'b10, 0);
    issue(0, 16'h0030, 16'h0, 2'b11, 0);
    issue(0, 16'h0030, 16'h0, 2'b00, 0);
    issue(1, 16'hFFFF, 16'hBEEF, 2'b11, 1); // R8 write straight after read
    issue(0, 16'hFFFF, 16'h0, 2'b11, 0);
    gap(4);
    issue(1, 16'h0040, 16'h7777, 2'b11, 0); // R8 gap still after idle
    for (int k = 0; k < 400; k++) begin
      logic [15:0] a;
      a = ($urandom % 2) ? 16'($urandom % 8) : 16'(16'hFFF8 + $urandom % 8);
      issue(1'($urandom), a, 16'($urandom), 2'($urandom), 1'($urandom));
      if ($urandom % 4 == 0) gap($urandom % 3);
    end
    gap(12);
    finish_run();
  end
endmodule